// File: doc/BRIEF.md
# Load-Use and Branch Stall Accounting Unit

This block watches the issue stream of a simple in-order core and keeps running totals of the pipeline penalties that stream would incur. Each issue event carries a unit class, up to two source register numbers with their own valid flags, a destination register number and, for control transfers, a taken flag. The block decides from its own bookkeeping whether the instruction would wait on an outstanding load result or on a redirected fetch. It reports that penalty on the same cycle and adds it to saturating counters.

Load results become visible as hazards one instruction group late. While a group is issuing, load destinations collect in a pending mask. A group-start strobe promotes that mask to the active mask, which the instructions of the new group are checked against, and starts an empty pending mask. A source that hits the active mask costs two cycles. A taken control transfer costs two more cycles on its own counter. The block does not steer the pipeline. It only measures it.

Top module: `stall_meter`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears all four counters, the active mask and the pending mask.
- R2: A valid load (iss_unit = 4) sets the pending bit of its dst register. That bit can cause a stall only after the next grp_start.
- R3: A valid execute (iss_unit = 0) or compare (iss_unit = 1) instruction checks src_a and src_b against the active mask. Each hit adds 2 to ld_stall_cnt, so two hits add 4.
- R4: A valid multiply-accumulate instruction (iss_unit = 2) checks both sources the same way as R3.
- R5: A valid control transfer (iss_unit = 3) checks only src_a for a load stall. src_b is ignored.
- R6: A taken control transfer (br_taken = 1) adds 2 to br_stall_cnt and 1 to taken_cnt. A not-taken one adds 1 to untaken_cnt only.
- R7: A valid store (iss_unit = 5) makes no stall check and does not change either mask.
- R8: On a cycle with grp_start high, the instruction on that cycle is checked against the previous pending mask. That mask becomes the active mask and the pending mask restarts empty. A load on the same cycle lands in the new pending mask.
- R9: A source whose valid flag (src_a_ok or src_b_ok) is low is never checked.
- R10: Every counter saturates at its all-ones value instead of wrapping.
- R11: issue_stall equals, on the same cycle, the load-stall plus branch-stall cycles that the current instruction adds.
- R12: With iss_valid low, or with unit codes 6 and 7, counters and masks are unchanged (apart from grp_start rotation) and issue_stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_unit | input | 3 | Unit class: 0 exec, 1 compare, 2 mac, 3 transfer, 4 load, 5 store |
| src_a | input | RW | First source register |
| src_a_ok | input | 1 | src_a is used by the instruction |
| src_b | input | RW | Second source register |
| src_b_ok | input | 1 | src_b is used by the instruction |
| dst | input | RW | Destination register (used by loads) |
| br_taken | input | 1 | Control transfer is taken |
| grp_start | input | 1 | First cycle of a new instruction group |
| issue_stall | output | 3 | Stall cycles charged to this cycle's instruction |
| ld_stall_cnt | output | CNT_W | Accumulated load-use stall cycles |
| br_stall_cnt | output | CNT_W | Accumulated control-transfer stall cycles |
| taken_cnt | output | CNT_W | Taken control transfers |
| untaken_cnt | output | CNT_W | Not-taken control transfers |

## Verification
The bench targets the one-group delay of load hazards. A load followed by a use inside the same group must cost nothing. A design that published loads immediately would charge two cycles there, and one that forgot to clear the pending mask would keep charging in later groups. It also targets a load issued on the grp_start cycle itself, a transfer whose unused src_b names a loaded register, stores and invalid sources that name loaded registers, and both sources of one instruction hitting the same register. A design that got any of these wrong would show a counter off by two. A narrow-counter instance is driven past its maximum, where a wrapping adder would fall back near zero.

// File: rtl/stall_meter.sv
module stall_meter #(
  parameter int NREG  = 16,
  parameter int CNT_W = 32,
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [2:0]       iss_unit,
  input  logic [RW-1:0]    src_a,
  input  logic             src_a_ok,
  input  logic [RW-1:0]    src_b,
  input  logic             src_b_ok,
  input  logic [RW-1:0]    dst,
  input  logic             br_taken,
  input  logic             grp_start,
  output logic [2:0]       issue_stall,
  output logic [CNT_W-1:0] ld_stall_cnt,
  output logic [CNT_W-1:0] br_stall_cnt,
  output logic [CNT_W-1:0] taken_cnt,
  output logic [CNT_W-1:0] untaken_cnt
);

  localparam logic [2:0] U_EXE = 3'd0;
  localparam logic [2:0] U_CMP = 3'd1;
  localparam logic [2:0] U_MAC = 3'd2;
  localparam logic [2:0] U_CTI = 3'd3;
  localparam logic [2:0] U_LD  = 3'd4;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [2:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  logic [NREG-1:0] act_q, pend_q, act_eff, pend_base, ld_bit;
  logic two_src, is_cti, is_ld;
  logic hit_a, hit_b;
  logic [2:0] ld_add, br_add;

  assign two_src = iss_valid && (iss_unit == U_EXE || iss_unit == U_CMP || iss_unit == U_MAC);
  assign is_cti  = iss_valid && iss_unit == U_CTI;
  assign is_ld   = iss_valid && iss_unit == U_LD;

  assign act_eff   = grp_start ? pend_q : act_q;
  assign pend_base = grp_start ? '0 : pend_q;
  assign ld_bit    = is_ld ? (NREG'(1) << dst) : '0;

  assign hit_a = (two_src || is_cti) && src_a_ok && act_eff[src_a];
  assign hit_b = two_src && src_b_ok && act_eff[src_b];

  assign ld_add      = {({1'b0, hit_a} + {1'b0, hit_b}), 1'b0};
  assign br_add      = (is_cti && br_taken) ? 3'd2 : 3'd0;
  assign issue_stall = ld_add + br_add;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q        <= '0;
      pend_q       <= '0;
      ld_stall_cnt <= '0;
      br_stall_cnt <= '0;
      taken_cnt    <= '0;
      untaken_cnt  <= '0;
    end else begin
      act_q        <= act_eff;
      pend_q       <= pend_base | ld_bit;
      ld_stall_cnt <= sat_add(ld_stall_cnt, ld_add);
      br_stall_cnt <= sat_add(br_stall_cnt, br_add);
      if (is_cti && br_taken)  taken_cnt   <= sat_add(taken_cnt, 3'd1);
      if (is_cti && !br_taken) untaken_cnt <= sat_add(untaken_cnt, 3'd1);
    end
  end

endmodule

// File: rtl/stall_meter_chk.sv
module stall_meter_chk #(
  parameter int NREG  = 16,
  parameter int CNT_W = 32,
  localparam int RW   = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [2:0]       iss_unit,
  input logic [RW-1:0]    src_a,
  input logic             src_a_ok,
  input logic [RW-1:0]    src_b,
  input logic             src_b_ok,
  input logic [RW-1:0]    dst,
  input logic             br_taken,
  input logic             grp_start,
  input logic [2:0]       issue_stall,
  input logic [CNT_W-1:0] ld_stall_cnt,
  input logic [CNT_W-1:0] br_stall_cnt,
  input logic [CNT_W-1:0] taken_cnt,
  input logic [CNT_W-1:0] untaken_cnt
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= rst_n;

  logic is_cti, idle;
  assign is_cti = iss_valid && iss_unit == 3'd3;
  assign idle   = !iss_valid || iss_unit == 3'd6 || iss_unit == 3'd7;

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (ld_stall_cnt == '0 && br_stall_cnt == '0 && taken_cnt == '0 && untaken_cnt == '0));

  assert_ld_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ld_stall_cnt >= $past(ld_stall_cnt));

  assert_store_no_charge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_unit == 3'd5) |=> $stable(ld_stall_cnt));

  assert_untaken_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cti && !br_taken && untaken_cnt != '1) |=>
      (untaken_cnt == $past(untaken_cnt) + 1'b1 && $stable(taken_cnt) && $stable(br_stall_cnt)));

  assert_noncti_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cti |=> ($stable(taken_cnt) && $stable(untaken_cnt) && $stable(br_stall_cnt)));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(ld_stall_cnt));

  always_comb begin
    if (rst_n && armed) begin
      assert_even_stall_R11: assert (issue_stall[0] == 1'b0 && issue_stall <= 3'd4);
      assert_idle_zero_R12:  assert (!idle || issue_stall == 3'd0);
    end
  end

endmodule

bind stall_meter stall_meter_chk #(.NREG(NREG), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_stall_meter.sv
`timescale 1ns/1ps
module tb_stall_meter;
  localparam int NW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, iss_valid = 1'b0, src_a_ok = 1'b0, src_b_ok = 1'b0, br_taken = 1'b0, grp_start = 1'b0;
  logic [2:0] iss_unit = '0;
  logic [3:0] src_a = '0, src_b = '0, dst = '0;
  logic [2:0] st_w, st_n;
  logic [31:0] ld_w, br_w, tk_w, un_w;
  logic [NW-1:0] ld_n, br_n, tk_n, un_n;

  stall_meter dut (.clk, .rst_n, .iss_valid, .iss_unit, .src_a, .src_a_ok, .src_b, .src_b_ok,
    .dst, .br_taken, .grp_start, .issue_stall(st_w), .ld_stall_cnt(ld_w), .br_stall_cnt(br_w),
    .taken_cnt(tk_w), .untaken_cnt(un_w));

  stall_meter #(.CNT_W(NW)) dut_sat (.clk, .rst_n, .iss_valid, .iss_unit, .src_a, .src_a_ok, .src_b,
    .src_b_ok, .dst, .br_taken, .grp_start, .issue_stall(st_n), .ld_stall_cnt(ld_n),
    .br_stall_cnt(br_n), .taken_cnt(tk_n), .untaken_cnt(un_n));

  int checks = 0, fails = 0;
  bit [15:0] m_act, m_pend;
  longint m_ld, m_br, m_tk, m_un;

  function automatic longint satv(longint x, int w);
    longint m = (longint'(1) << w) - 1;
    return (x > m) ? m : x;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_counters(string tag);
    chk({tag, " R3"}, "ld_stall_cnt", longint'(ld_w), satv(m_ld, 32));
    chk({tag, " R6"}, "br_stall_cnt", longint'(br_w), satv(m_br, 32));
    chk({tag, " R6"}, "taken_cnt", longint'(tk_w), satv(m_tk, 32));
    chk({tag, " R6"}, "untaken_cnt", longint'(un_w), satv(m_un, 32));
    chk({tag, " R10"}, "narrow ld", longint'(ld_n), satv(m_ld, NW));
    chk({tag, " R10"}, "narrow br", longint'(br_n), satv(m_br, NW));
    chk({tag, " R10"}, "narrow taken", longint'(tk_n), satv(m_tk, NW));
    chk({tag, " R10"}, "narrow untaken", longint'(un_n), satv(m_un, NW));
  endtask

  task automatic step(bit v, bit [2:0] u, bit [3:0] a, bit aok, bit [3:0] b, bit bok,
                      bit [3:0] d, bit tk, bit g, string tag);
    bit [15:0] eff;
    bit two, cti, ha, hb;
    int lda, bra;
    iss_valid = v; iss_unit = u; src_a = a; src_a_ok = aok; src_b = b; src_b_ok = bok;
    dst = d; br_taken = tk; grp_start = g;
    #1;
    eff = g ? m_pend : m_act;
    two = v && (u <= 3'd2);
    cti = v && (u == 3'd3);
    ha  = (two || cti) && aok && eff[a];
    hb  = two && bok && eff[b];
    lda = 2 * (int'(ha) + int'(hb));
    bra = (cti && tk) ? 2 : 0;
    chk({tag, " R11"}, "issue_stall", longint'(st_w), lda + bra);
    m_pend = g ? 16'h0 : m_pend;
    if (v && u == 3'd4) m_pend[d] = 1'b1;
    m_act = eff;
    m_ld += lda;
    m_br += bra;
    if (cti && tk)  m_tk++;
    if (cti && !tk) m_un++;
    @(posedge clk); #1;
    chk_counters(tag);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; iss_valid = 1'b0; grp_start = 1'b0;
    @(posedge clk); #1;
    m_act = '0; m_pend = '0; m_ld = 0; m_br = 0; m_tk = 0; m_un = 0;
    @(negedge clk);
    rst_n = 1'b1;
    chk_counters("R1 reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R2: load then use within the same group costs nothing
    step(1, 3'd4, 0, 0, 0, 0, 4'd5, 0, 1, "R2 load");
    step(1, 3'd0, 4'd5, 1, 4'd5, 1, 0, 0, 0, "R2 same-group use");
    // R8/R3: after group start both sources hit the same register -> +4
    step(1, 3'd0, 4'd5, 1, 4'd5, 1, 0, 0, 1, "R8 promote");
    step(1, 3'd1, 4'd5, 1, 4'd2, 1, 0, 0, 0, "R3 compare hit");
    // R9: invalid sources are ignored
    step(1, 3'd0, 4'd5, 0, 4'd5, 0, 0, 0, 0, "R9 invalid srcs");
    // R4: multiply-accumulate second source
    step(1, 3'd2, 4'd1, 1, 4'd5, 1, 0, 0, 0, "R4 mac");
    // R5: transfer ignores src_b, taken -> R6
    step(1, 3'd3, 4'd0, 1, 4'd5, 1, 0, 1, 0, "R5 cti src_b");
    step(1, 3'd3, 4'd5, 1, 4'd0, 0, 0, 1, 0, "R5 cti src_a taken");
    step(1, 3'd3, 4'd5, 0, 4'd0, 0, 0, 0, 0, "R6 untaken");
    // R7: store neither checks nor marks
    step(1, 3'd5, 4'd5, 1, 4'd5, 1, 4'd9, 0, 0, "R7 store");
    step(1, 3'd0, 4'd9, 1, 4'd9, 1, 0, 0, 1, "R7 store left no mark");
    // R12: unknown unit codes and idle cycles do nothing
    step(1, 3'd6, 4'd5, 1, 4'd5, 1, 4'd3, 1, 0, "R12 code6");
    step(0, 3'd4, 4'd5, 1, 4'd5, 1, 4'd3, 1, 0, "R12 idle");
    step(1, 3'd0, 4'd3, 1, 4'd3, 1, 0, 0, 1, "R12 no mark from idle");
    // R8: load on the grp_start cycle goes to the new pending mask
    step(1, 3'd4, 0, 0, 0, 0, 4'd7, 0, 1, "R8 load on boundary");
    step(1, 3'd0, 4'd7, 1, 4'd0, 0, 0, 0, 0, "R8 not yet active");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, "R8 boundary");
    step(1, 3'd0, 4'd7, 1, 4'd0, 0, 0, 0, 0, "R8 now active");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, "R8 pending cleared");
    step(1, 3'd0, 4'd7, 1, 4'd0, 0, 0, 0, 0, "R8 stale cleared");
    // R1: reset mid-run clears masks too
    step(1, 3'd4, 0, 0, 0, 0, 4'd4, 0, 0, "R1 preload");
    step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, "R1 promote");
    do_reset();
    step(1, 3'd0, 4'd4, 1, 4'd4, 1, 0, 0, 1, "R1 mask cleared");
    // random traffic, narrow instance saturates (R10)
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)), 4'($urandom_range(0, 3)),
           1'($urandom_range(0, 3) != 0), 4'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0),
           4'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
           "R10 random");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule